// File: doc/BRIEF.md
# Interrupt Gate Descriptor Fetch Unit

This block turns an interrupt or exception vector into the 8-byte gate descriptor that serves it. It keeps a table register made of a 32-bit linear base and a 16-bit limit. The limit gives the offset of the last valid byte, so a limit of zero leaves exactly one byte valid. The register can be written only at privilege level 0. It can be read back at any privilege level.

When a vector is accepted, the unit computes the descriptor offset as the vector times eight. It then checks that all eight bytes of the entry lie at or below the limit. An entry that is out of range, even by one byte, gives a general-protection fault, and no memory traffic takes place. An entry that is in range is read through a valid/ready request port and a response port. The present flag of the returned entry then decides between handing out the descriptor and raising a not-present fault. Only one vector is processed at a time.

The control is a five-state machine:
- `ST_IDLE` accepts a vector and moves to `ST_EVAL`.
- `ST_EVAL` runs the bounds check. It moves to `ST_ISSUE` when the entry is in range, or to `ST_DONE` with a protection fault when it is not.
- `ST_ISSUE` holds the memory request until it is taken, then moves to `ST_WAIT`.
- `ST_WAIT` takes the response and moves to `ST_DONE`, with either a gate result or a not-present result.
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `gate_fetch_unit`

## Requirements
- R1: After reset the table base and limit are both 0, `vec_ready` is 1, and `res_valid`, `mem_req_valid`, `ld_fault` and `rd_valid` are 0.
- R2: A load request (`ld_req`) while `cpl` is 0 writes `ld_base` and `ld_limit` into the table register. The new value is visible from the next cycle.
- R3: A load request while `cpl` is not 0 leaves the table register unchanged. It raises `ld_fault` for one cycle, in the cycle after the request.
- R4: A read-back request (`rd_req`) at any `cpl` raises `rd_valid` one cycle later, with `rd_base` and `rd_limit` equal to the register contents.
- R5: The descriptor read address is base + vector × 8, modulo 2^32. Vector 0 is a legal entry at the base itself.
- R6: An entry is in range only when vector × 8 + 7 ≤ limit, compared without wrap-around. An entry out of range gives a result with `res_gp_fault` = 1, and no memory request is made.
- R7: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. Exactly one request is made per in-range lookup.
- R8: When bit 47 of the returned descriptor is 0, the result has `res_np_fault` = 1. When it is 1, the result has both fault flags at 0 and `res_desc` equal to the returned 64-bit word. Every result carries the vector in `res_vec`.
- R9: `vec_ready` is 0 from acceptance until the result has been shown. `res_valid` lasts exactly one cycle, and the two fault flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl | input | 2 | Current privilege level |
| ld_req | input | 1 | Request to load the table register |
| ld_base | input | 32 | Base value to load |
| ld_limit | input | 16 | Limit value to load |
| ld_fault | output | 1 | One-cycle protection fault for a load refused at nonzero privilege |
| rd_req | input | 1 | Request to read back the table register |
| rd_valid | output | 1 | Read-back data valid |
| rd_base | output | 32 | Read-back base |
| rd_limit | output | 16 | Read-back limit |
| vec_valid | input | 1 | Vector offered |
| vec | input | 8 | Interrupt or exception vector |
| vec_ready | output | 1 | Unit idle and able to take a vector |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Linear address of the descriptor |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Returned descriptor |
| res_valid | output | 1 | Result valid for one cycle |
| res_desc | output | 64 | Descriptor for a gate result, otherwise 0 |
| res_gp_fault | output | 1 | General-protection fault (entry beyond the limit) |
| res_np_fault | output | 1 | Not-present fault |
| res_vec | output | 8 | Vector that the result belongs to |

## Verification
Lookups are run with vector 0, a middle vector and vector 255. The limit is set to exactly cover a whole entry, to fall one byte short, to 0, and to the 16-bit maximum. These cases separate a check on the last byte from a check on the first byte or on the entry count. A base near the top of the address space shows whether the address wraps. A request held for several cycles shows whether the address stays stable. Descriptors with bit 47 set and clear tell the gate result from the not-present fault. Load attempts at levels 0 and 3, each followed by a read-back at level 3, confirm that writes are gated and reads are not.

// File: rtl/gate_fetch_pkg.sv
package gate_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fetch_state_e;

    typedef enum logic [1:0] {
        RES_GATE,
        RES_GP,
        RES_NP
    } res_kind_e;

endpackage

// File: rtl/gate_tbl_reg.sv
module gate_tbl_reg #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16,
    parameter int CPL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPL_W-1:0]  cpl,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic              rd_req,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [LIM_W-1:0]  tbl_limit,
    output logic              ld_fault,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit
);

    logic priv_ok;

    // Writes are allowed only at the most privileged level.
    assign priv_ok = (cpl == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base  <= '0;
            tbl_limit <= '0;
            ld_fault  <= 1'b0;
        end else begin
            ld_fault <= ld_req && !priv_ok;
            if (ld_req && priv_ok) begin
                tbl_base  <= ld_base;
                tbl_limit <= ld_limit;
            end
        end
    end

    // Read-back is open at every privilege level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_base  <= '0;
            rd_limit <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_base  <= tbl_base;
                rd_limit <= tbl_limit;
            end
        end
    end

endmodule

// File: rtl/gate_bounds_chk.sv
module gate_bounds_chk #(
    parameter int ADDR_W      = 32,
    parameter int LIM_W       = 16,
    parameter int VEC_W       = 8,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    output logic              in_bounds,
    output logic [ADDR_W-1:0] desc_addr
);

    localparam int OFF_W       = VEC_W + ENTRY_SHIFT;
    localparam int CMP_W       = ((OFF_W > LIM_W) ? OFF_W : LIM_W) + 1;
    localparam int ENTRY_BYTES = 1 << ENTRY_SHIFT;

    logic [CMP_W-1:0]  first_byte;
    logic [CMP_W-1:0]  last_byte;
    logic [CMP_W-1:0]  lim_wide;
    logic [ADDR_W-1:0] off_addr;

    // The widened compare keeps the sum of offset and entry size from wrapping.
    always_comb begin
        first_byte = {{(CMP_W-VEC_W){1'b0}}, vec} << ENTRY_SHIFT;
        last_byte  = first_byte + CMP_W'(ENTRY_BYTES - 1);
        lim_wide   = {{(CMP_W-LIM_W){1'b0}}, limit};
        in_bounds  = (last_byte <= lim_wide);
        off_addr   = {{(ADDR_W-VEC_W){1'b0}}, vec} << ENTRY_SHIFT;
        desc_addr  = base + off_addr;
    end

endmodule

// File: rtl/gate_fetch_fsm.sv
module gate_fetch_fsm
    import gate_fetch_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 8,
    parameter int DESC_W      = 64,
    parameter int PRESENT_BIT = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec,
    output logic              vec_ready,
    output logic [VEC_W-1:0]  cur_vec,
    input  logic              in_bounds,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [DESC_W-1:0] res_desc,
    output logic              res_gp_fault,
    output logic              res_np_fault,
    output logic [VEC_W-1:0]  res_vec
);

    fetch_state_e      state_q, state_d;
    res_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DESC_W-1:0] desc_q;
    logic [VEC_W-1:0]  vec_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (vec_valid)     state_d = ST_EVAL;
            ST_EVAL:  state_d = in_bounds ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RES_GATE;
            addr_q <= '0;
            desc_q <= '0;
            vec_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (vec_valid) begin
                        vec_q  <= vec;
                        desc_q <= '0;
                        kind_q <= RES_GATE;
                    end
                end
                ST_EVAL: begin
                    if (in_bounds) addr_q <= desc_addr;
                    else           kind_q <= RES_GP;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_data[PRESENT_BIT]) begin
                            desc_q <= mem_rsp_data;
                            kind_q <= RES_GATE;
                        end else begin
                            kind_q <= RES_NP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        vec_ready     = 1'b0;
        mem_req_valid = 1'b0;
        res_valid     = 1'b0;
        res_gp_fault  = 1'b0;
        res_np_fault  = 1'b0;
        res_desc      = '0;
        unique case (state_q)
            ST_IDLE:  vec_ready = 1'b1;
            ST_EVAL:  ;
            ST_ISSUE: mem_req_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE: begin
                res_valid    = 1'b1;
                res_gp_fault = (kind_q == RES_GP);
                res_np_fault = (kind_q == RES_NP);
                res_desc     = (kind_q == RES_GATE) ? desc_q : '0;
            end
            default: ;
        endcase
    end

    assign cur_vec      = vec_q;
    assign res_vec      = vec_q;
    assign mem_req_addr = addr_q;

endmodule

// File: rtl/gate_fetch_unit.sv
module gate_fetch_unit #(
    parameter int ADDR_W      = 32,
    parameter int LIM_W       = 16,
    parameter int VEC_W       = 8,
    parameter int CPL_W       = 2,
    parameter int DESC_W      = 64,
    parameter int PRESENT_BIT = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPL_W-1:0]  cpl,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    output logic              ld_fault,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec,
    output logic              vec_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [DESC_W-1:0] res_desc,
    output logic              res_gp_fault,
    output logic              res_np_fault,
    output logic [VEC_W-1:0]  res_vec
);

    localparam int ENTRY_SHIFT = $clog2(DESC_W / 8);

    logic [ADDR_W-1:0] tbl_base;
    logic [LIM_W-1:0]  tbl_limit;
    logic [VEC_W-1:0]  cur_vec;
    logic              in_bounds;
    logic [ADDR_W-1:0] desc_addr;

    gate_tbl_reg #(
        .ADDR_W (ADDR_W),
        .LIM_W  (LIM_W),
        .CPL_W  (CPL_W)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpl       (cpl),
        .ld_req    (ld_req),
        .ld_base   (ld_base),
        .ld_limit  (ld_limit),
        .rd_req    (rd_req),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .ld_fault  (ld_fault),
        .rd_valid  (rd_valid),
        .rd_base   (rd_base),
        .rd_limit  (rd_limit)
    );

    gate_bounds_chk #(
        .ADDR_W      (ADDR_W),
        .LIM_W       (LIM_W),
        .VEC_W       (VEC_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_bounds (
        .vec       (cur_vec),
        .base      (tbl_base),
        .limit     (tbl_limit),
        .in_bounds (in_bounds),
        .desc_addr (desc_addr)
    );

    gate_fetch_fsm #(
        .ADDR_W      (ADDR_W),
        .VEC_W       (VEC_W),
        .DESC_W      (DESC_W),
        .PRESENT_BIT (PRESENT_BIT)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .vec_valid     (vec_valid),
        .vec           (vec),
        .vec_ready     (vec_ready),
        .cur_vec       (cur_vec),
        .in_bounds     (in_bounds),
        .desc_addr     (desc_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_desc      (res_desc),
        .res_gp_fault  (res_gp_fault),
        .res_np_fault  (res_np_fault),
        .res_vec       (res_vec)
    );

endmodule

// File: rtl/gate_fetch_chk.sv
module gate_fetch_chk #(
    parameter int ADDR_W      = 32,
    parameter int LIM_W       = 16,
    parameter int CPL_W       = 2,
    parameter int DESC_W      = 64,
    parameter int PRESENT_BIT = 47
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CPL_W-1:0]  cpl,
    input logic              ld_req,
    input logic              ld_fault,
    input logic [ADDR_W-1:0] tbl_base,
    input logic [LIM_W-1:0]  tbl_limit,
    input logic              vec_ready,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              res_valid,
    input logic [DESC_W-1:0] res_desc,
    input logic              res_gp_fault,
    input logic              res_np_fault
);

    a_r3_refused_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && cpl != '0) |=> (ld_fault && $stable(tbl_base) && $stable(tbl_limit)));

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r8_gate_present: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_gp_fault && !res_np_fault) |-> res_desc[PRESENT_BIT]);

    a_r9_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_gp_fault && res_np_fault));

    a_r9_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || mem_req_valid) |-> !vec_ready);

endmodule

bind gate_fetch_unit gate_fetch_chk #(
    .ADDR_W      (ADDR_W),
    .LIM_W       (LIM_W),
    .CPL_W       (CPL_W),
    .DESC_W      (DESC_W),
    .PRESENT_BIT (PRESENT_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpl           (cpl),
    .ld_req        (ld_req),
    .ld_fault      (ld_fault),
    .tbl_base      (tbl_base),
    .tbl_limit     (tbl_limit),
    .vec_ready     (vec_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .res_valid     (res_valid),
    .res_desc      (res_desc),
    .res_gp_fault  (res_gp_fault),
    .res_np_fault  (res_np_fault)
);

// File: tb/gate_fetch_unit_test.sv
`timescale 1ns/1ps
module gate_fetch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        ld_req = 1'b0;
    logic [31:0] ld_base = '0;
    logic [15:0] ld_limit = '0;
    logic        ld_fault;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_base;
    logic [15:0] rd_limit;
    logic        vec_valid = 1'b0;
    logic [7:0]  vec = '0;
    logic        vec_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [63:0] res_desc;
    logic        res_gp_fault;
    logic        res_np_fault;
    logic [7:0]  res_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int K_GATE = 0;
    localparam int K_GP   = 1;
    localparam int K_NP   = 2;

    always #4 clk = ~clk;

    gate_fetch_unit uut (
        .clk(clk), .rst_n(rst_n), .cpl(cpl),
        .ld_req(ld_req), .ld_base(ld_base), .ld_limit(ld_limit), .ld_fault(ld_fault),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_base(rd_base), .rd_limit(rd_limit),
        .vec_valid(vec_valid), .vec(vec), .vec_ready(vec_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_desc(res_desc), .res_gp_fault(res_gp_fault),
        .res_np_fault(res_np_fault), .res_vec(res_vec)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, act=%0d cycles exp<=20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic load_tbl(input logic [1:0] lvl, input logic [31:0] b,
                            input logic [15:0] l, input bit exp_fault, input string tag);
        @(negedge clk);
        cpl = lvl; ld_base = b; ld_limit = l; ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0; cpl = 2'd0;
        chk(ld_fault == exp_fault, tag, "ld_fault", 64'(ld_fault), 64'(exp_fault));
        @(negedge clk);
        chk(ld_fault == 1'b0, tag, "ld_fault pulse end", 64'(ld_fault), 64'd0);
    endtask

    task automatic read_tbl(input logic [1:0] lvl, input logic [31:0] eb,
                            input logic [15:0] el, input string tag);
        @(negedge clk);
        cpl = lvl; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; cpl = 2'd0;
        chk(rd_valid == 1'b1, tag, "rd_valid", 64'(rd_valid), 64'd1);
        chk(rd_base == eb, tag, "rd_base", 64'(rd_base), 64'(eb));
        chk(rd_limit == el, tag, "rd_limit", 64'(rd_limit), 64'(el));
    endtask

    task automatic do_lookup(input logic [7:0] v, input bit present, input int delay,
                             input int expk, input logic [31:0] expaddr, input string tag);
        logic [63:0] d;
        logic [31:0] a_cap;
        bit got, hs, seen;
        int waits, nreq;
        logic gp, np;
        logic [63:0] rdesc;
        logic [7:0] rvec;
        d = '0; a_cap = '0; got = 0; hs = 0; seen = 0; waits = 0; nreq = 0;
        gp = 0; np = 0; rdesc = '0; rvec = '0;
        @(negedge clk);
        chk(vec_ready == 1'b1, tag, "vec_ready before offer", 64'(vec_ready), 64'd1);
        vec = v; vec_valid = 1'b1;
        @(negedge clk);
        vec_valid = 1'b0;
        chk(vec_ready == 1'b0, "R9", "vec_ready while busy", 64'(vec_ready), 64'd0);
        for (int c = 0; c < 40 && !got; c++) begin
            if (res_valid) begin
                got = 1; gp = res_gp_fault; np = res_np_fault;
                rdesc = res_desc; rvec = res_vec;
            end
            mem_rsp_valid = 1'b0;
            if (!got) begin
                if (hs) begin
                    mem_req_ready = 1'b0;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = d;
                    hs = 0;
                end else if (mem_req_valid) begin
                    if (seen)
                        chk(mem_req_addr == a_cap, "R7", "addr stable while held",
                            64'(mem_req_addr), 64'(a_cap));
                    else
                        nreq = nreq + 1;
                    seen = 1; a_cap = mem_req_addr;
                    if (waits >= delay) begin
                        mem_req_ready = 1'b1; hs = 1;
                        d = {a_cap, 8'h5A, v, 16'hBEEF};
                        d[47] = present;
                    end else begin
                        waits = waits + 1;
                    end
                end
                @(negedge clk);
            end
        end
        mem_req_ready = 1'b0;
        chk(got, tag, "result seen", 64'(got), 64'd1);
        chk(rvec == v, tag, "res_vec", 64'(rvec), 64'(v));
        chk(gp == (expk == K_GP), tag, "gp flag", 64'(gp), 64'(expk == K_GP));
        chk(np == (expk == K_NP), tag, "np flag", 64'(np), 64'(expk == K_NP));
        chk(nreq == ((expk == K_GP) ? 0 : 1), tag, "request count", 64'(nreq),
            64'((expk == K_GP) ? 0 : 1));
        if (expk != K_GP)
            chk(a_cap == expaddr, tag, "descriptor address", 64'(a_cap), 64'(expaddr));
        if (expk == K_GATE)
            chk(rdesc == d, tag, "descriptor data", rdesc, d);
        @(negedge clk);
        chk(res_valid == 1'b0, "R9", "res_valid one cycle", 64'(res_valid), 64'd0);
        chk(vec_ready == 1'b1, "R9", "ready after result", 64'(vec_ready), 64'd1);
    endtask

    task automatic t_reset;
        chk(vec_ready == 1'b1, "R1", "vec_ready", 64'(vec_ready), 64'd1);
        chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk(ld_fault == 1'b0, "R1", "ld_fault", 64'(ld_fault), 64'd0);
        chk(rd_valid == 1'b0, "R1", "rd_valid", 64'(rd_valid), 64'd0);
        read_tbl(2'd3, 32'h0, 16'h0, "R1");
    endtask

    task automatic t_load_rules;
        load_tbl(2'd0, 32'h1000_0000, 16'h07FF, 1'b0, "R2");
        read_tbl(2'd3, 32'h1000_0000, 16'h07FF, "R4");
        load_tbl(2'd3, 32'hDEAD_0000, 16'h0010, 1'b1, "R3");
        read_tbl(2'd0, 32'h1000_0000, 16'h07FF, "R3");
        load_tbl(2'd1, 32'h2222_0000, 16'h0001, 1'b1, "R3");
        read_tbl(2'd2, 32'h1000_0000, 16'h07FF, "R4");
    endtask

    task automatic t_addressing;
        do_lookup(8'd0, 1'b1, 0, K_GATE, 32'h1000_0000, "R5");
        do_lookup(8'd37, 1'b1, 2, K_GATE, 32'h1000_0128, "R5");
        do_lookup(8'd255, 1'b1, 3, K_GATE, 32'h1000_07F8, "R7");
        load_tbl(2'd0, 32'hFFFF_FFF8, 16'hFFFF, 1'b0, "R2");
        do_lookup(8'd1, 1'b1, 0, K_GATE, 32'h0000_0000, "R5");
        do_lookup(8'd255, 1'b1, 1, K_GATE, 32'h0000_07F0, "R6");
    endtask

    task automatic t_bounds;
        load_tbl(2'd0, 32'h0004_0000, 16'h000F, 1'b0, "R2");
        do_lookup(8'd1, 1'b1, 0, K_GATE, 32'h0004_0008, "R6");
        do_lookup(8'd2, 1'b1, 0, K_GP, 32'h0, "R6");
        load_tbl(2'd0, 32'h0004_0000, 16'h000E, 1'b0, "R2");
        do_lookup(8'd1, 1'b1, 0, K_GP, 32'h0, "R6");
        do_lookup(8'd0, 1'b1, 0, K_GATE, 32'h0004_0000, "R6");
        load_tbl(2'd0, 32'h0004_0000, 16'h0000, 1'b0, "R2");
        do_lookup(8'd0, 1'b1, 0, K_GP, 32'h0, "R6");
        load_tbl(2'd0, 32'h0004_0000, 16'h07FE, 1'b0, "R2");
        do_lookup(8'd255, 1'b1, 0, K_GP, 32'h0, "R6");
    endtask

    task automatic t_present;
        load_tbl(2'd0, 32'h0008_0000, 16'h00FF, 1'b0, "R2");
        do_lookup(8'd5, 1'b0, 1, K_NP, 32'h0008_0028, "R8");
        do_lookup(8'd6, 1'b1, 0, K_GATE, 32'h0008_0030, "R8");
        do_lookup(8'd31, 1'b0, 0, K_NP, 32'h0008_00F8, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_rules();
        t_addressing();
        t_bounds();
        t_present();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule